// File: doc/BRIEF.md
# Four-Channel Programmed-I/O Character Port

This block sits on an 8-bit processor I/O bus and gives software four character channels. Each channel owns two bus addresses. The status address reports whether a received character is waiting and whether the channel can take a character to send. The data address returns the held received character, or accepts a character to send. The line side is abstracted as one valid/ready character stream per direction and per channel. Serial framing and bit timing belong to other blocks.

Three global mode inputs shape the character path. One swaps the backspace and delete codes on reads. One folds lowercase letters to uppercase on reads. One clears bit 7 of every character written for transmission. A special command byte written to a status address returns that channel to its power-up state. Addresses that no channel claims read as all ones, and writes to them are dropped.

Top module: `mpio_serial_hub`

## Requirements
- R1: A status read returns bit 0 = received character waiting and bit 1 = transmit ready, with bits 7..2 reading 0.
- R2: Channel 0 uses status/data addresses 0x10/0x11, channel 1 uses 0x14/0x15, channel 2 uses 0x16/0x17 and channel 3 uses 0x18/0x19.
- R3: After reset, the channel 0 status is 0x02 and the status of every other channel is 0x00. The held received character of every channel is 0x00.
- R4: Writing 0x03 to a status address returns that channel to its R3 state on the next cycle. This holds over any same-cycle arrival or line-ready. Any other value written to a status address changes nothing.
- R5: A data read returns the held character and clears status bit 0 of that channel from the next cycle.
- R6: A character that arrives (rx_valid high) is held and sets status bit 0, replacing any unread character. If it arrives in the same cycle as a data read of its channel, the read returns the old character and bit 0 stays set.
- R7: With mode_del_map high, a held 0x08 reads as 0x7F. With it low, a held 0x7F reads as 0x08. Other codes are not changed by this mode.
- R8: With mode_upcase high, held codes 0x61..0x7A read as the code minus 0x20.
- R9: With mode_strip7 high, a data write presents the character with bit 7 forced to 0 on tx_data. With the mode low, the character is presented unchanged.
- R10: A data write makes tx_valid high and clears status bit 1 on the next cycle. tx_valid and tx_data then hold until a cycle with tx_ready high. Status bit 1 becomes 1 on the cycle after any cycle in which tx_ready is high and no data write occurs.
- R11: A read of an address not listed in R2 returns 0xFF, and a write to such an address changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O bus address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address (combinational) |
| mode_del_map | input | 1 | Backspace/delete direction select for reads |
| mode_upcase | input | 1 | Fold lowercase to uppercase on reads |
| mode_strip7 | input | 1 | Clear bit 7 of transmitted characters |
| rx_valid | input | 4 | Per-channel received character strobe |
| rx_data | input | 32 | Received characters, channel n in bits 8n+7..8n |
| tx_ready | input | 4 | Per-channel line-side acceptance |
| tx_valid | output | 4 | Per-channel character-to-send valid |
| tx_data | output | 32 | Characters to send, channel n in bits 8n+7..8n |

## Verification
Two pairs of events can land in the same cycle. A line-side arrival can meet a software data read of the same channel. A data write can meet tx_ready. The bench forces both pairs on purpose. It does this in directed steps and in a long random stretch where strobes, arrivals and line-ready all toggle freely. A behavioural reference model judges each cycle. A coincident read must return the old character while the flag stays set. A write that meets tx_ready must leave the new character pending with transmit-ready low.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CHAN_RESET_CMD = 8'h03;
  localparam logic [BYTE_W-1:0] FLOAT_BUS      = 8'hFF;
  localparam logic [BYTE_W-1:0] CODE_BS        = 8'h08;
  localparam logic [BYTE_W-1:0] CODE_DEL       = 8'h7F;

  // status address of channel ch; data address is the next one up
  function automatic logic [BYTE_W-1:0] stat_addr(input int unsigned ch);
    logic [BYTE_W-1:0] a;
    if (ch == 0)      a = 8'h10;
    else if (ch == 1) a = 8'h14;
    else if (ch == 2) a = 8'h16;
    else if (ch == 3) a = 8'h18;
    else              a = BYTE_W'(32'h20 + 2 * ch);
    return a;
  endfunction

  function automatic logic [BYTE_W-1:0] data_addr(input int unsigned ch);
    return stat_addr(ch) + 8'd1;
  endfunction

  // {tx ready, rx waiting} after reset
  function automatic logic [1:0] idle_status(input int unsigned ch);
    return (ch == 0) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [BYTE_W-1:0] rx_view(input logic [BYTE_W-1:0] c,
                                                input logic del_map,
                                                input logic upcase);
    logic [BYTE_W-1:0] r;
    r = c;
    if (del_map && c == CODE_BS)        r = CODE_DEL;
    else if (!del_map && c == CODE_DEL) r = CODE_BS;
    if (upcase && r >= 8'h61 && r <= 8'h7A) r = r - 8'h20;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] tx_view(input logic [BYTE_W-1:0] c,
                                                input logic strip);
    return strip ? {1'b0, c[BYTE_W-2:0]} : c;
  endfunction
endpackage

// File: rtl/mpio_addr_dec.sv
module mpio_addr_dec
  import mpio_pkg::*;
#(
  parameter int unsigned N_CHAN = 4
) (
  input  logic [BYTE_W-1:0] addr,
  output logic [N_CHAN-1:0] st_hit,
  output logic [N_CHAN-1:0] dt_hit,
  output logic              any_hit
);
  for (genvar g = 0; g < N_CHAN; g++) begin : g_cmp
    assign st_hit[g] = (addr == stat_addr(g));
    assign dt_hit[g] = (addr == data_addr(g));
  end
  assign any_hit = |{st_hit, dt_hit};
endmodule

// File: rtl/mpio_chan.sv
module mpio_chan
  import mpio_pkg::*;
#(
  parameter int unsigned CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_hit,
  input  logic              dt_hit,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [BYTE_W-1:0] io_wdata,
  input  logic              strip7,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] rx_hold
);
  localparam logic [1:0] IDLE_ST = idle_status(CH_IDX);

  // named events
  logic cmd_reset, take_rx, put_tx;
  assign cmd_reset = io_wr && st_hit && (io_wdata == CHAN_RESET_CMD);
  assign take_rx   = io_rd && dt_hit;
  assign put_tx    = io_wr && dt_hit;

  logic rx_flag, tx_rdy, tx_pend, overrun;
  logic [BYTE_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_reset) begin
      {tx_rdy, rx_flag} <= IDLE_ST;
      rx_hold <= '0;
      tx_pend <= 1'b0;
      tx_q    <= '0;
      overrun <= 1'b0;
    end else begin
      if (rx_valid) begin
        rx_hold <= rx_data;
        rx_flag <= 1'b1;
        if (rx_flag && !take_rx) overrun <= 1'b1;
      end else if (take_rx) begin
        rx_flag <= 1'b0;
      end
      if (put_tx) begin
        tx_q    <= tx_view(io_wdata, strip7);
        tx_pend <= 1'b1;
        tx_rdy  <= 1'b0;
      end else if (tx_ready) begin
        tx_pend <= 1'b0;
        tx_rdy  <= 1'b1;
      end
    end
  end

  assign status   = {tx_rdy, rx_flag};
  assign tx_valid = tx_pend;
  assign tx_data  = tx_q;

  a_r4_cmd_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (status == IDLE_ST && rx_hold == '0 && !tx_valid));
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rx && !rx_valid && !cmd_reset) |=> !status[0]);
  a_r6_arrival_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cmd_reset) |=> (status[0] && rx_hold == $past(rx_data)));
  a_r6_overrun_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && status[0] && !take_rx && !cmd_reset) |=> overrun);
  a_r9_strip: assert property (@(posedge clk) disable iff (!rst_n)
    (put_tx && strip7 && !cmd_reset) |=> !tx_data[BYTE_W-1]);
  a_r10_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (put_tx && !cmd_reset) |=> (tx_valid && !status[1]));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !put_tx && !cmd_reset) |=> (tx_valid && $stable(tx_data)));
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !status[1]);
endmodule

// File: rtl/mpio_serial_hub.sv
module mpio_serial_hub
  import mpio_pkg::*;
#(
  parameter int unsigned N_CHAN = 4,
  localparam int unsigned LANE_W = N_CHAN * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  input  logic              mode_del_map,
  input  logic              mode_upcase,
  input  logic              mode_strip7,
  input  logic [N_CHAN-1:0] rx_valid,
  input  logic [LANE_W-1:0] rx_data,
  input  logic [N_CHAN-1:0] tx_ready,
  output logic [N_CHAN-1:0] tx_valid,
  output logic [LANE_W-1:0] tx_data
);
  logic [N_CHAN-1:0] st_hit, dt_hit;
  logic              any_hit;
  logic [1:0]        stat_v [N_CHAN];
  logic [BYTE_W-1:0] hold_v [N_CHAN];

  mpio_addr_dec #(.N_CHAN(N_CHAN)) dec_i (
    .addr(io_addr), .st_hit(st_hit), .dt_hit(dt_hit), .any_hit(any_hit)
  );

  for (genvar g = 0; g < N_CHAN; g++) begin : g_ch
    mpio_chan #(.CH_IDX(g)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .st_hit(st_hit[g]), .dt_hit(dt_hit[g]),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
      .strip7(mode_strip7),
      .rx_valid(rx_valid[g]), .rx_data(rx_data[g*BYTE_W +: BYTE_W]),
      .tx_ready(tx_ready[g]), .tx_valid(tx_valid[g]),
      .tx_data(tx_data[g*BYTE_W +: BYTE_W]),
      .status(stat_v[g]), .rx_hold(hold_v[g])
    );
  end

  always_comb begin
    io_rdata = FLOAT_BUS;
    for (int i = 0; i < N_CHAN; i++) begin
      if (st_hit[i]) io_rdata = {6'b0, stat_v[i]};
      if (dt_hit[i]) io_rdata = rx_view(hold_v[i], mode_del_map, mode_upcase);
    end
  end

  a_r11_float_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !any_hit) |-> io_rdata == FLOAT_BUS);
  a_r2_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_hit, dt_hit}));
  a_r1_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && |st_hit) |-> io_rdata[7:2] == 6'b0);
endmodule

// File: tb/mpio_serial_hub_tb.sv
module mpio_serial_hub_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        mode_del_map = 1'b0, mode_upcase = 1'b0, mode_strip7 = 1'b0;
  logic [3:0]  rx_valid = '0, tx_ready = '0, tx_valid;
  logic [31:0] rx_data = '0, tx_data;

  mpio_serial_hub dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mode_del_map(mode_del_map),
    .mode_upcase(mode_upcase), .mode_strip7(mode_strip7), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  int n_chk = 0, n_fail = 0;
  int last_rd;
  int ports [4] = '{'h10, 'h14, 'h16, 'h18};

  // behavioural reference
  int m_flag [4], m_char [4], m_rdy [4], m_busy [4], m_out [4];

  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (!rst_n || (io_wr && io_addr == ports[c] && io_wdata == 3)) begin
        m_flag[c] = 0; m_char[c] = 0; m_busy[c] = 0; m_out[c] = 0;
        m_rdy[c] = (c == 0) ? 1 : 0;
      end else begin
        if (rx_valid[c]) begin
          m_char[c] = rx_data[c*8 +: 8]; m_flag[c] = 1;
        end else if (io_rd && io_addr == ports[c] + 1) m_flag[c] = 0;
        if (io_wr && io_addr == ports[c] + 1) begin
          m_busy[c] = 1; m_rdy[c] = 0;
          m_out[c] = mode_strip7 ? (io_wdata % 128) : io_wdata;
        end else if (tx_ready[c]) begin
          m_busy[c] = 0; m_rdy[c] = 1;
        end
      end
    end
  end

  function automatic int shown(int v);
    int r = v;
    if (mode_del_map) begin if (v == 8) r = 127; end
    else if (v == 127) r = 8;
    if (mode_upcase && r >= 97 && r <= 122) r = r - 32;
    return r;
  endfunction

  function automatic int expect_rd(int a);
    for (int c = 0; c < 4; c++) begin
      if (a == ports[c]) return m_rdy[c] * 2 + m_flag[c];
      if (a == ports[c] + 1) return shown(m_char[c]);
    end
    return 255;
  endfunction

  function automatic string tag_of(int a);
    for (int c = 0; c < 4; c++) begin
      if (a == ports[c]) return "R1";
      if (a == ports[c] + 1) return "R5";
    end
    return "R11";
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
    io_addr = a; io_rd = r; io_wr = w; io_wdata = d;
    #1;
    last_rd = int'(io_rdata);
    if (r) chk(tag_of(a), last_rd, expect_rd(a));
    for (int c = 0; c < 4; c++) begin
      chk("R10", int'(tx_valid[c]), m_busy[c]);
      if (m_busy[c] != 0) chk("R9", int'(tx_data[c*8 +: 8]), m_out[c]);
    end
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic push(int c, int v);
    rx_valid[c] = 1'b1; rx_data[c*8 +: 8] = v[7:0];
    step(8'h00, 0, 0, 8'h00);
    rx_valid = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    step(8'h10, 1, 0, 0); chk("R3", last_rd, 8'h02);
    step(8'h14, 1, 0, 0); chk("R3", last_rd, 8'h00);
    step(8'h19, 1, 0, 0); chk("R3", last_rd, 8'h00);
    // R11 floating reads
    step(8'h12, 1, 0, 0); chk("R11", last_rd, 8'hFF);
    step(8'h1A, 1, 0, 0); chk("R11", last_rd, 8'hFF);
    // R8 upcase, R5 clear on read
    mode_upcase = 1'b1;
    push(1, 'h61);
    step(8'h14, 1, 0, 0); chk("R1", last_rd, 8'h01);
    step(8'h15, 1, 0, 0); chk("R8", last_rd, 8'h41);
    step(8'h14, 1, 0, 0); chk("R5", last_rd, 8'h00);
    // R7 swap both directions
    mode_upcase = 1'b0; mode_del_map = 1'b0;
    push(2, 'h7F); step(8'h17, 1, 0, 0); chk("R7", last_rd, 8'h08);
    mode_del_map = 1'b1;
    push(2, 'h08); step(8'h17, 1, 0, 0); chk("R7", last_rd, 8'h7F);
    push(2, 'h41); step(8'h17, 1, 0, 0); chk("R7", last_rd, 8'h41);
    // R6 overwrite and coincident read
    push(3, 'h11); push(3, 'h22);
    step(8'h18, 1, 0, 0); chk("R6", last_rd, 8'h01);
    step(8'h19, 1, 0, 0); chk("R6", last_rd, 8'h22);
    push(3, 'h33);
    rx_valid[3] = 1'b1; rx_data[31:24] = 8'h44;
    step(8'h19, 1, 0, 0); chk("R6", last_rd, 8'h33);
    rx_valid = '0;
    step(8'h18, 1, 0, 0); chk("R6", last_rd, 8'h01);
    step(8'h19, 1, 0, 0); chk("R6", last_rd, 8'h44);
    // R9 strip and R10 handshake
    mode_strip7 = 1'b1;
    step(8'h11, 0, 1, 8'hC1);
    chk("R9", int'(tx_data[7:0]), 8'h41); chk("R10", int'(tx_valid[0]), 1);
    step(8'h10, 1, 0, 0); chk("R10", last_rd, 8'h00);
    tx_ready[0] = 1'b1; step(8'h00, 0, 0, 0); tx_ready[0] = 1'b0;
    step(8'h10, 1, 0, 0); chk("R10", last_rd, 8'h02);
    chk("R10", int'(tx_valid[0]), 0);
    mode_strip7 = 1'b0;
    step(8'h11, 0, 1, 8'hC1); chk("R9", int'(tx_data[7:0]), 8'hC1);
    // write meets tx_ready in the same cycle
    tx_ready[0] = 1'b1; step(8'h11, 0, 1, 8'h5A); tx_ready[0] = 1'b0;
    chk("R10", int'(tx_valid[0]), 1); chk("R10", int'(tx_data[7:0]), 8'h5A);
    // R4 reset command versus other codes
    push(1, 'h55);
    step(8'h14, 0, 1, 8'h05); step(8'h14, 1, 0, 0); chk("R4", last_rd, 8'h01);
    step(8'h14, 0, 1, 8'h03); step(8'h14, 1, 0, 0); chk("R4", last_rd, 8'h00);
    step(8'h15, 1, 0, 0); chk("R3", last_rd, 8'h00);
    step(8'h10, 0, 1, 8'h03);
    chk("R4", int'(tx_valid[0]), 0);
    step(8'h10, 1, 0, 0); chk("R4", last_rd, 8'h02);
    // R11 writes to unclaimed addresses
    push(2, 'h66);
    step(8'h12, 0, 1, 8'h03); step(8'h13, 0, 1, 8'h77);
    step(8'h16, 1, 0, 0); chk("R11", last_rd, 8'h01);
    chk("R11", int'(tx_valid), 0);
    // R2 address map, all channels line-ready
    tx_ready = 4'hF; step(8'h00, 0, 0, 0);
    step(8'h10, 1, 0, 0); chk("R2", last_rd, 8'h02);
    step(8'h14, 1, 0, 0); chk("R2", last_rd, 8'h02);
    step(8'h16, 1, 0, 0); chk("R2", last_rd, 8'h03);
    step(8'h18, 1, 0, 0); chk("R2", last_rd, 8'h02);
    // random stretch against the reference
    for (int i = 0; i < 1500; i++) begin
      int pick, sel;
      logic [7:0] a, d;
      logic r, w;
      pick = $urandom_range(0, 9);
      sel  = $urandom_range(0, 3);
      a = (pick < 4) ? 8'(ports[sel]) : (pick < 8) ? 8'(ports[sel] + 1) : 8'($urandom_range(0, 255));
      r = 1'($urandom_range(0, 1));
      w = !r && ($urandom_range(0, 2) == 0);
      d = ($urandom_range(0, 3) == 0) ? 8'h03 : 8'($urandom_range(0, 255));
      rx_valid = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      rx_data = $urandom();
      tx_ready = 4'($urandom_range(0, 15));
      mode_del_map = 1'($urandom_range(0, 1));
      mode_upcase = 1'($urandom_range(0, 1));
      mode_strip7 = 1'($urandom_range(0, 1));
      step(a, r, w, d);
      rx_valid = '0;
    end
    finish_run();
  end
endmodule